// File: doc/BRIEF.md
# Subcarrier Permutation Writer with Ping-Pong Symbol Store

This block reorders a stream of complex frequency-domain values into their permuted subcarrier positions inside one OFDM symbol. Each accepted value is written straight to its final location, so the reordering adds no latency. The location is computed on the fly from three counters: the subcarrier index k inside a subchannel, the subchannel index s inside a major group, and the major group index. A symbol has 1440 values spread over six major groups.

Storage is split into two banks of 1440 words. While one bank fills, the other is read out in plain ascending address order. The next stage sees a linear symbol stream and needs no knowledge of the permutation. Both edges are valid/ready streams. A value moves on a clock edge where valid and ready are both high. A source may not withdraw valid or change data while it waits. `in_ready` drops only when both banks hold symbols that have not yet been read. When `out_ready` is low, the output value and its tags stay frozen.

Top module: `pusc_perm_writer`

## Requirements
- R1: Input values arrive with k counting fastest (0..23), then s, then the group. Inside a group with N subchannels, a value goes to position N·nk + P[(s+nk) mod N], with nk = (k + 13·s) mod 24. P is the permutation table for that group size. The default 12-entry table, by index 0..11, is 6,9,4,8,10,11,5,2,7,3,1,0. The default 8-entry table, by index 0..7, is 7,4,0,2,1,5,3,6.
- R2: Groups 0, 2 and 4 have 12 subchannels (288 values each). Groups 1, 3 and 5 have 8 subchannels (192 values each). The offset of a group within the symbol is the sum of the sizes of the groups before it: 0, 288, 480, 768, 960 and 1248.
- R3: A stored symbol is emitted at positions 0 to 1439 in ascending order. `out_index` carries the position of each value. `out_last` is high only on position 1439.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_index` and `out_last` hold their values.
- R5: Once two complete symbols wait unread, `in_ready` is low. No input is taken while it stays low. No value is lost or duplicated across such a stall.
- R6: Reading a full bank overlaps with filling the other bank. With `out_ready` held high, input is accepted on every cycle without a stall. Output runs at one value per cycle within a symbol.
- R7: After reset, `out_valid` is low and `in_ready` is high. Both banks are empty. The next input value is taken as k=0, s=0 of group 0.
- R8: Symbols leave in the same order in which they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 32 | Complex input value (two 16-bit parts) |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block can take an input value |
| out_data | output | 32 | Complex value at the current position |
| out_valid | output | 1 | Output value present |
| out_ready | input | 1 | Downstream takes the output value |
| out_index | output | 11 | Subcarrier position of the output value |
| out_last | output | 1 | Output value is position 1439 |

## Verification
Some properties are checked by assertions on every cycle. These are: write addresses stay inside a symbol; the output is frozen under back-pressure; the position steps by one between accepted values; the last flag marks only position 1439; the write bank is never the bank being read; and `in_ready` only falls right after an accepted write. The bench scenarios are the only place where the permutation itself is checked. They compare whole symbols against a formula computed separately, with a table of hand-worked positions across even and odd groups. The scenarios also cover a full stall with both banks occupied, symbol ordering, and a reset in the middle of a symbol.

// File: rtl/pusc_pkg.sv
package pusc_pkg;
  // Default permutation tables, entry i in bits [4*i +: 4].
  localparam logic [47:0] DEF_PERM_EVEN = 48'h013725BA8496;
  localparam logic [31:0] DEF_PERM_ODD  = 32'h63512047;

  // Number of values in one symbol: even groups use n_even subchannels.
  function automatic int sym_len(int sc, int groups, int n_even, int n_odd);
    return sc * (n_even * ((groups + 1) / 2) + n_odd * (groups / 2));
  endfunction
endpackage

// File: rtl/pusc_addr_gen.sv
module pusc_addr_gen
  import pusc_pkg::*;
#(
  parameter int SC        = 24,
  parameter int NK_STEP   = 13,
  parameter int N_GROUPS  = 6,
  parameter int NSUB_EVEN = 12,
  parameter int NSUB_ODD  = 8,
  parameter int PB_W      = 4,
  parameter logic [NSUB_EVEN*PB_W-1:0] PERM_EVEN = DEF_PERM_EVEN,
  parameter logic [NSUB_ODD*PB_W-1:0]  PERM_ODD  = DEF_PERM_ODD,
  parameter int A_W       = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  output logic [A_W-1:0] addr,
  output logic           sym_last
);
  localparam int K_W = $clog2(SC);
  localparam int S_W = $clog2(NSUB_EVEN);
  localparam int G_W = $clog2(N_GROUPS);
  localparam int RED_STEPS = (NSUB_EVEN + SC - 2) / NSUB_ODD;

  logic [K_W-1:0] k_q, t_q;
  logic [S_W-1:0] s_q;
  logic [G_W-1:0] g_q;
  logic [A_W-1:0] base_q;
  int nsub;

  assign nsub = g_q[0] ? NSUB_ODD : NSUB_EVEN;

  // Address: compare-and-subtract replaces every modulo.
  always_comb begin
    int nk, j, pb;
    nk = int'(k_q) + int'(t_q);
    if (nk >= SC) nk = nk - SC;
    j = int'(s_q) + nk;
    for (int i = 0; i < RED_STEPS; i++)
      if (j >= nsub) j = j - nsub;
    if (g_q[0]) pb = int'(PERM_ODD[j*PB_W +: PB_W]);
    else        pb = int'(PERM_EVEN[j*PB_W +: PB_W]);
    addr = A_W'(int'(base_q) + nsub * nk + pb);
  end

  assign sym_last = (int'(k_q) == SC - 1) && (int'(s_q) == nsub - 1) &&
                    (int'(g_q) == N_GROUPS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q <= '0; s_q <= '0; g_q <= '0; t_q <= '0; base_q <= '0;
    end else if (step) begin
      if (int'(k_q) == SC - 1) begin
        k_q <= '0;
        if (int'(s_q) == nsub - 1) begin
          s_q <= '0;
          t_q <= '0;
          if (int'(g_q) == N_GROUPS - 1) begin
            g_q    <= '0;
            base_q <= '0;
          end else begin
            g_q    <= g_q + 1'b1;
            base_q <= A_W'(int'(base_q) + SC * nsub);
          end
        end else begin
          s_q <= s_q + 1'b1;
          if (int'(t_q) + NK_STEP >= SC) t_q <= K_W'(int'(t_q) + NK_STEP - SC);
          else                           t_q <= K_W'(int'(t_q) + NK_STEP);
        end
      end else begin
        k_q <= k_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pusc_bank_ram.sv
module pusc_bank_ram #(
  parameter int DATA_W  = 32,
  parameter int SYM_LEN = 1440,
  parameter int A_W     = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wbank,
  input  logic [A_W-1:0]    waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic              rbank,
  input  logic [A_W-1:0]    raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 * SYM_LEN;
  localparam int M_W   = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [M_W-1:0] wa, ra;

  assign wa = M_W'(int'(wbank) * SYM_LEN + int'(waddr));
  assign ra = M_W'(int'(rbank) * SYM_LEN + int'(raddr));

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wdata;
    if (re) rdata <= mem[ra];
  end
endmodule

// File: rtl/pusc_read_seq.sv
module pusc_read_seq #(
  parameter int SYM_LEN = 1440,
  parameter int A_W     = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bank_full,
  input  logic           out_ready,
  output logic           rd_en,
  output logic [A_W-1:0] rd_addr,
  output logic           rd_done,
  output logic           out_valid,
  output logic [A_W-1:0] out_index,
  output logic           out_last
);
  logic [A_W-1:0] cnt_q;
  logic at_end;

  assign at_end  = (int'(cnt_q) == SYM_LEN - 1);
  assign rd_en   = bank_full && (!out_valid || out_ready);
  assign rd_addr = cnt_q;
  assign rd_done = rd_en && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; out_valid <= 1'b0; out_index <= '0; out_last <= 1'b0;
    end else if (rd_en) begin
      cnt_q     <= at_end ? '0 : cnt_q + 1'b1;
      out_valid <= 1'b1;
      out_index <= cnt_q;
      out_last  <= at_end;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pusc_perm_writer.sv
module pusc_perm_writer
  import pusc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SC        = 24,
  parameter int NK_STEP   = 13,
  parameter int N_GROUPS  = 6,
  parameter int NSUB_EVEN = 12,
  parameter int NSUB_ODD  = 8,
  parameter int PB_W      = 4,
  parameter logic [NSUB_EVEN*PB_W-1:0] PERM_EVEN = DEF_PERM_EVEN,
  parameter logic [NSUB_ODD*PB_W-1:0]  PERM_ODD  = DEF_PERM_ODD,
  localparam int SYM_LEN = sym_len(SC, N_GROUPS, NSUB_EVEN, NSUB_ODD),
  localparam int IDX_W   = $clog2(SYM_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_index,
  output logic              out_last
);
  logic [1:0] full_q, full_d;
  logic wb_q, rb_q;
  logic wr_en, wr_last, rd_en, rd_done;
  logic [IDX_W-1:0] wr_addr, rd_addr;

  assign in_ready = !full_q[wb_q];
  assign wr_en    = in_valid && in_ready;

  pusc_addr_gen #(
    .SC(SC), .NK_STEP(NK_STEP), .N_GROUPS(N_GROUPS),
    .NSUB_EVEN(NSUB_EVEN), .NSUB_ODD(NSUB_ODD), .PB_W(PB_W),
    .PERM_EVEN(PERM_EVEN), .PERM_ODD(PERM_ODD), .A_W(IDX_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .step(wr_en), .addr(wr_addr), .sym_last(wr_last)
  );

  pusc_read_seq #(.SYM_LEN(SYM_LEN), .A_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .bank_full(full_q[rb_q]), .out_ready(out_ready),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_done(rd_done),
    .out_valid(out_valid), .out_index(out_index), .out_last(out_last)
  );

  pusc_bank_ram #(.DATA_W(DATA_W), .SYM_LEN(SYM_LEN), .A_W(IDX_W)) u_ram (
    .clk(clk), .we(wr_en), .wbank(wb_q), .waddr(wr_addr), .wdata(in_data),
    .re(rd_en), .rbank(rb_q), .raddr(rd_addr), .rdata(out_data)
  );

  always_comb begin
    full_d = full_q;
    if (wr_en && wr_last) full_d[wb_q] = 1'b1;
    if (rd_done)          full_d[rb_q] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0; wb_q <= 1'b0; rb_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (wr_en && wr_last) wb_q <= ~wb_q;
      if (rd_done)          rb_q <= ~rb_q;
    end
  end
endmodule

// File: rtl/pusc_perm_writer_chk.sv
module pusc_perm_writer_chk #(
  parameter int DATA_W  = 32,
  parameter int SYM_LEN = 1440,
  parameter int IDX_W   = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDX_W-1:0]  out_index,
  input logic              out_last,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wb_q,
  input logic              rb_q,
  input logic [IDX_W-1:0]  wr_addr
);
  // R1: computed write position lies inside the symbol
  a_r1_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < SYM_LEN));

  // R4: output frozen under back-pressure
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_index) && $stable(out_last)));

  // R3: last flag marks only the final position
  a_r3_last_mark: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (int'(out_index) == SYM_LEN - 1)));

  // R3: positions ascend by one inside a symbol
  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (!out_valid || (out_index == $past(out_index) + 1'b1)));

  // R6: the bank being written is never the bank being read
  a_r6_banks_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |-> (wb_q != rb_q));

  // R5: ready falls only after a completed write
  a_r5_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && in_ready));
endmodule

bind pusc_perm_writer pusc_perm_writer_chk #(
  .DATA_W(DATA_W), .SYM_LEN(SYM_LEN), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_index(out_index), .out_last(out_last), .wr_en(wr_en), .rd_en(rd_en),
  .wb_q(wb_q), .rb_q(rb_q), .wr_addr(wr_addr)
);

// File: tb/pusc_perm_writer_tb.sv
module pusc_perm_writer_tb;
  localparam int LEN = 1440;
  localparam int NV  = 13;
  // {input ordinal, expected position} worked by hand from R1/R2
  localparam int VEC_N [NV] = '{0, 1, 23, 24, 47, 287, 288, 289, 312, 479, 480, 960, 1439};
  localparam int VEC_A [NV] = '{6, 21, 276, 160, 153, 267, 295, 300, 395, 436, 486, 966, 1396};
  localparam int PB12 [12] = '{6, 9, 4, 8, 10, 11, 5, 2, 7, 3, 1, 0};
  localparam int PB8  [8]  = '{7, 4, 0, 2, 1, 5, 3, 6};

  logic clk = 0, rst_n = 0;
  logic [31:0] in_data = '0;
  logic in_valid = 0, out_ready = 0;
  logic in_ready, out_valid, out_last;
  logic [31:0] out_data;
  logic [10:0] out_index;

  always #10 clk = ~clk;

  pusc_perm_writer u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_index(out_index), .out_last(out_last)
  );

  int checks = 0, errors = 0;
  int inv [LEN];
  int rx0 [LEN];
  int rx_sym = 0, rx_idx = 0, sym_err = 0, idx_err = 0, last_err = 0;
  int hold_err = 0, gap_cnt = 0, stalls = 0;
  bit gap_on = 0, prev_stall = 0;
  logic [31:0] prev_data;
  logic [10:0] prev_idx;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent position formula (R1, R2)
  initial begin
    int n, base;
    n = 0; base = 0;
    for (int g = 0; g < 6; g++) begin
      int ns;
      ns = (g % 2) ? 8 : 12;
      for (int s = 0; s < ns; s++)
        for (int k = 0; k < 24; k++) begin
          int nk, a;
          nk = (k + 13 * s) % 24;
          a = base + ns * nk + ((g % 2) ? PB8[(s + nk) % ns] : PB12[(s + nk) % ns]);
          inv[a] = n;
          n++;
        end
      base += 24 * ns;
    end
  end

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      rx_idx = 0; prev_stall = 0;
    end else begin
      if (prev_stall && (out_valid !== 1'b1 || out_data !== prev_data || out_index !== prev_idx))
        hold_err++;
      if (gap_on && rx_idx > 0 && out_ready && !out_valid) gap_cnt++;
      if (out_valid && out_ready) begin
        if (out_data !== {rx_sym[15:0], inv[rx_idx][15:0]}) sym_err++;
        if (int'(out_index) != rx_idx) idx_err++;
        if (out_last !== (rx_idx == LEN - 1)) last_err++;
        if (rx_sym == 0) rx0[rx_idx] = int'(out_data[15:0]);
        if (rx_idx == LEN - 1) begin
          check(sym_err == 0, "R1 R2 R8 symbol content", sym_err, 0);
          check(idx_err == 0 && last_err == 0, "R3 position and last flag",
                idx_err + last_err, 0);
          sym_err = 0; idx_err = 0; last_err = 0; rx_idx = 0; rx_sym++;
        end else rx_idx++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data; prev_idx = out_index;
    end
  end

  task automatic send_values(input int sym, input int count);
    for (int n = 0; n < count; n++) begin
      bit acc;
      in_valid = 1; in_data = {sym[15:0], n[15:0]};
      do begin
        @(negedge clk); acc = in_ready;
        if (!acc) stalls++;
        @(posedge clk); #1;
      end while (!acc);
    end
    in_valid = 0;
  endtask

  task automatic wait_rx(input int target);
    while (rx_sym < target) @(posedge clk);
    #1;
  endtask

  bit done = 0;
  bit bp_on = 0;

  // Back-pressure pattern driver
  initial begin
    int c;
    c = 0;
    forever begin
      @(posedge clk); #1;
      if (bp_on) out_ready = (c % 3) != 0;
      c++;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    check(out_valid == 0, "R7 out_valid in reset", out_valid, 0);
    check(in_ready == 1, "R7 in_ready in reset", in_ready, 1);
    rst_n = 1;
    @(posedge clk); #1;

    // Scenario 1: continuous drain, overlap of read and write (R6)
    out_ready = 1; gap_on = 1; stalls = 0;
    send_values(0, LEN);
    send_values(1, LEN);
    check(stalls == 0, "R6 no input stall with free drain", stalls, 0);
    wait_rx(2);
    gap_on = 0;
    check(gap_cnt == 0, "R6 one value per cycle", gap_cnt, 0);
    for (int i = 0; i < NV; i++)
      check(rx0[VEC_A[i]] == VEC_N[i], (VEC_N[i] < 288) ? "R1 table position" : "R2 group table position",
            rx0[VEC_A[i]], VEC_N[i]);

    // Scenario 2: irregular back-pressure (R4, R8)
    bp_on = 1; hold_err = 0;
    send_values(2, LEN);
    send_values(3, LEN);
    wait_rx(4);
    bp_on = 0; #1 out_ready = 1;
    check(hold_err == 0, "R4 output held while stalled", hold_err, 0);

    // Scenario 3: both banks occupied (R5)
    @(posedge clk); #1;
    out_ready = 0;
    send_values(4, LEN);
    send_values(5, LEN);
    fork
      send_values(6, LEN);
      begin
        repeat (30) @(posedge clk);
        @(negedge clk);
        check(in_ready == 0, "R5 in_ready low with two full banks", in_ready, 0);
        check(out_valid == 1 && out_index == 0, "R4 first value held", int'(out_index), 0);
        @(posedge clk); #1;
        out_ready = 1;
      end
    join
    wait_rx(7);
    check(rx_sym == 7, "R5 R8 all stalled symbols delivered in order", rx_sym, 7);

    // Scenario 4: reset in the middle of a symbol (R7)
    send_values(99, 500);
    rst_n = 0;
    @(negedge clk);
    check(out_valid == 0 && in_ready == 1, "R7 state after mid-symbol reset",
          {out_valid, in_ready}, 1);
    @(posedge clk); #1; rst_n = 1;
    send_values(7, LEN);
    wait_rx(8);
    check(rx_sym == 8, "R7 restart from group 0", rx_sym, 8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule